// File: doc/BRIEF.md
# Segment Lookaside Buffer with Hinted Bulk Invalidation

This block is a small, fully associative table of segment translations for a 64-bit hashed memory-management unit. Every entry holds an effective segment identifier with its valid bit, the virtual segment identifier it maps to, and a one-bit class tag. Software loads an entry by index. The address path looks up an effective segment identifier and gets back a hit flag and the mapped virtual segment identifier. A single-entry invalidate removes the entry whose identifier matches a given value.

The bulk invalidate command carries the raw instruction word. A 3-bit hint sits at bits [23:21] of that word. The hint decides whether entry 0 is spared, whether class-0 entries survive, or whether the table is left alone. In every one of these cases the bulk invalidate requests a translation-cache flush. The flush cannot depend on what was cleared, because a plain entry write may already have replaced a valid translation without any flush. A static mode input selects between the older behaviour, where every hint acts like hint 0, and the newer behaviour, where the hint is decoded in full. The bulk command clears all selected entries in parallel in one clock edge.

Top module: `seg_lookaside_buf`

## Requirements
- R1: After reset, every entry is invalid. A lookup misses, and `flush_req`, `bulk_done` and `bad_hint` are low.
- R2: A write with no invalidate in the same cycle stores the identifier, the mapping and the class into entry `wr_idx` and makes that entry valid at the next clock edge. It does not raise `flush_req`.
- R3: Lookup is combinational over the stored state. `lk_hit` is 1 only when a valid entry's identifier equals `lk_esid`, and `lk_vsid` then gives that entry's mapping. When several valid entries match, the lowest index wins. When no valid entry matches, `lk_hit` is 0 and `lk_vsid` is 0.
- R4: Each bulk invalidate raises `flush_req` and `bulk_done` for exactly the one cycle after the edge that accepts it. This happens for every hint value and in either mode, even when no valid entry is cleared.
- R5: The hint is `bulk_op[23:21]`. No other bit of `bulk_op` affects the result.
- R6: In the older mode (`newer_mode`=0), every hint value clears the valid bit of entries 1 to NUM_ENT-1 and leaves entry 0 unchanged. In the newer mode, hints 0, 1, 2 and 6 do the same.
- R7: In the newer mode, hint 3 clears every valid entry whose class bit is 1, entry 0 included. Entries with class bit 0 stay valid.
- R8: In the newer mode, hint 4 clears every entry, entry 0 included.
- R9: In the newer mode, hint 7 leaves every entry unchanged.
- R10: Hint 5 clears entries the same way hint 0 does. In the newer mode it also raises `bad_hint` for one cycle. In the older mode `bad_hint` stays low.
- R11: A single invalidate clears every valid entry whose identifier equals `inv_esid`. It raises `flush_req` for one cycle, whether or not an entry matched.
- R12: When an invalidate of either kind arrives in the same cycle as a write, the write is dropped. When a bulk invalidate and a single invalidate arrive together, only the bulk invalidate takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| newer_mode | input | 1 | Static mode select: 1 decodes the hint in full, 0 treats every hint as hint 0 |
| wr_en | input | 1 | Write an entry |
| wr_idx | input | IDX_W | Index of the entry to write |
| wr_esid | input | ESID_W | Effective segment identifier to store |
| wr_vsid | input | VSID_W | Virtual segment identifier to store |
| wr_class | input | 1 | Class tag to store |
| inv_en | input | 1 | Single-entry invalidate |
| inv_esid | input | ESID_W | Identifier to invalidate |
| bulk_en | input | 1 | Bulk invalidate |
| bulk_op | input | OP_W | Instruction word that carries the hint at [23:21] |
| lk_esid | input | ESID_W | Lookup key |
| lk_hit | output | 1 | A valid entry matches the lookup key |
| lk_vsid | output | VSID_W | Mapping of the lowest-index matching entry |
| flush_req | output | 1 | One-cycle translation-cache flush request |
| bulk_done | output | 1 | One-cycle pulse after a bulk invalidate |
| bad_hint | output | 1 | One-cycle pulse after a bulk invalidate with undefined hint 5 in the newer mode |

## Verification
The properties assume that `newer_mode` does not change in a cycle where a bulk invalidate is being decoded. The bench changes the mode only while every command input is idle. The properties on entry 0 and on hints 4 and 7 also rely on a bulk invalidate overriding any write or single invalidate in the same cycle. The bench therefore drives such collisions on purpose and checks the result only through lookups. The bench sets every `bulk_op` bit outside the hint field to a fixed non-zero pattern, so any extraction from the wrong bits changes which entries survive.

// File: rtl/slb_pkg.sv
package slb_pkg;
   // Position of the 3-bit bulk-invalidate hint inside the instruction word
   localparam int HINT_LSB = 21;
   localparam int HINT_W   = 3;

   // Decoded selection for one bulk invalidate
   typedef struct packed {
      logic keep_zero;   // entry 0 is spared
      logic class_only;  // only class-1 entries are cleared
      logic touch_none;  // nothing is cleared
      logic bad;         // undefined hint seen
   } bulk_sel_t;
endpackage

// File: rtl/slb_hint_dec.sv
module slb_hint_dec
   import slb_pkg::*;
#(
   parameter int OP_W = 32
) (
   input  logic [OP_W-1:0] op,
   input  logic            newer,
   output bulk_sel_t       sel
);
   if (OP_W < HINT_LSB + HINT_W) begin : g_bad_width
      $error("slb_hint_dec: OP_W too small to hold the hint field");
   end

   logic [HINT_W-1:0] hint;
   assign hint = op[HINT_LSB +: HINT_W];

   always_comb begin
      sel = '{keep_zero: 1'b1, class_only: 1'b0, touch_none: 1'b0, bad: 1'b0};
      if (newer) begin
         case (hint)
            3'd3: begin
               sel.keep_zero  = 1'b0;
               sel.class_only = 1'b1;
            end
            3'd4: sel.keep_zero  = 1'b0;
            3'd5: sel.bad        = 1'b1;
            3'd7: sel.touch_none = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/slb_cam.sv
module slb_cam #(
   parameter int N     = 8,
   parameter int KEY_W = 36
) (
   input  logic [N-1:0][KEY_W-1:0] keys,
   input  logic [N-1:0]            vld,
   input  logic [KEY_W-1:0]        probe,
   output logic [N-1:0]            hit
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit[g] = vld[g] && (keys[g] == probe);
   end
endmodule

// File: rtl/slb_store.sv
module slb_store #(
   parameter  int N      = 8,
   parameter  int ESID_W = 36,
   parameter  int VSID_W = 52,
   localparam int IDX_W  = $clog2(N)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [ESID_W-1:0]        wr_esid,
   input  logic [VSID_W-1:0]        wr_vsid,
   input  logic                     wr_class,
   input  logic [N-1:0]             clr,
   output logic [N-1:0]             vld,
   output logic [N-1:0]             cls,
   output logic [N-1:0][ESID_W-1:0] esid,
   output logic [N-1:0][VSID_W-1:0] vsid
);
   for (genvar g = 0; g < N; g++) begin : g_ent
      logic              v_q;
      logic              c_q;
      logic [ESID_W-1:0] e_q;
      logic [VSID_W-1:0] s_q;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      v_q <= 1'b0;
         else if (clr[g]) v_q <= 1'b0;
         else if (sel)    v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel && !clr[g]) begin
            c_q <= wr_class;
            e_q <= wr_esid;
            s_q <= wr_vsid;
         end
      end

      assign vld[g]  = v_q;
      assign cls[g]  = c_q;
      assign esid[g] = e_q;
      assign vsid[g] = s_q;
   end
endmodule

// File: rtl/seg_lookaside_buf.sv
module seg_lookaside_buf
   import slb_pkg::*;
#(
   parameter  int NUM_ENT = 8,
   parameter  int ESID_W  = 36,
   parameter  int VSID_W  = 52,
   parameter  int OP_W    = 32,
   localparam int IDX_W   = $clog2(NUM_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              newer_mode,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ESID_W-1:0] wr_esid,
   input  logic [VSID_W-1:0] wr_vsid,
   input  logic              wr_class,
   input  logic              inv_en,
   input  logic [ESID_W-1:0] inv_esid,
   input  logic              bulk_en,
   input  logic [OP_W-1:0]   bulk_op,
   input  logic [ESID_W-1:0] lk_esid,
   output logic              lk_hit,
   output logic [VSID_W-1:0] lk_vsid,
   output logic              flush_req,
   output logic              bulk_done,
   output logic              bad_hint
);
   if (NUM_ENT < 2 || (NUM_ENT & (NUM_ENT - 1)) != 0) begin : g_bad_depth
      $error("seg_lookaside_buf: NUM_ENT must be a power of two, at least 2");
   end
   if (ESID_W < 1 || VSID_W < 1) begin : g_bad_fields
      $error("seg_lookaside_buf: field widths must be positive");
   end

   logic [NUM_ENT-1:0]             vld_q;
   logic [NUM_ENT-1:0]             cls_q;
   logic [NUM_ENT-1:0][ESID_W-1:0] esid_q;
   logic [NUM_ENT-1:0][VSID_W-1:0] vsid_q;
   logic [NUM_ENT-1:0]             lk_match;
   logic [NUM_ENT-1:0]             inv_match;
   logic [NUM_ENT-1:0]             clr;
   logic                           wr_take;
   bulk_sel_t                      sel;

   slb_hint_dec #(.OP_W(OP_W)) u_dec (
      .op    (bulk_op),
      .newer (newer_mode),
      .sel   (sel)
   );

   slb_cam #(.N(NUM_ENT), .KEY_W(ESID_W)) u_cam_lk (
      .keys  (esid_q),
      .vld   (vld_q),
      .probe (lk_esid),
      .hit   (lk_match)
   );

   slb_cam #(.N(NUM_ENT), .KEY_W(ESID_W)) u_cam_inv (
      .keys  (esid_q),
      .vld   (vld_q),
      .probe (inv_esid),
      .hit   (inv_match)
   );

   // Clear mask: bulk has priority over the single invalidate
   for (genvar g = 0; g < NUM_ENT; g++) begin : g_clr
      logic spare;
      if (g == 0) begin : g_zero
         assign spare = sel.keep_zero;
      end else begin : g_rest
         assign spare = 1'b0;
      end
      assign clr[g] = bulk_en
                      ? (!sel.touch_none && !spare && (!sel.class_only || cls_q[g]))
                      : (inv_en && inv_match[g]);
   end

   // Any invalidate wins over a write in the same cycle
   assign wr_take = wr_en && !inv_en && !bulk_en;

   slb_store #(.N(NUM_ENT), .ESID_W(ESID_W), .VSID_W(VSID_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_take),
      .wr_idx   (wr_idx),
      .wr_esid  (wr_esid),
      .wr_vsid  (wr_vsid),
      .wr_class (wr_class),
      .clr      (clr),
      .vld      (vld_q),
      .cls      (cls_q),
      .esid     (esid_q),
      .vsid     (vsid_q)
   );

   // Lowest matching index wins
   always_comb begin
      lk_hit  = 1'b0;
      lk_vsid = '0;
      for (int i = NUM_ENT - 1; i >= 0; i--) begin
         if (lk_match[i]) begin
            lk_hit  = 1'b1;
            lk_vsid = vsid_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_req <= 1'b0;
         bulk_done <= 1'b0;
         bad_hint  <= 1'b0;
      end else begin
         flush_req <= bulk_en || inv_en;
         bulk_done <= bulk_en;
         bad_hint  <= bulk_en && sel.bad;
      end
   end
endmodule

// File: rtl/slb_chk.sv
module slb_chk #(
   parameter int NUM_ENT = 8,
   parameter int IDX_W   = 3,
   parameter int OP_W    = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               newer_mode,
   input logic               wr_en,
   input logic [IDX_W-1:0]   wr_idx,
   input logic               inv_en,
   input logic               bulk_en,
   input logic [OP_W-1:0]    bulk_op,
   input logic               lk_hit,
   input logic               flush_req,
   input logic               bulk_done,
   input logic               bad_hint,
   input logic [NUM_ENT-1:0] vld
);
   logic [2:0]       hint;
   logic             wr_take_d;
   logic [IDX_W-1:0] wr_idx_d;

   assign hint = bulk_op[slb_pkg::HINT_LSB +: 3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_take_d <= 1'b0;
         wr_idx_d  <= '0;
      end else begin
         wr_take_d <= wr_en && !inv_en && !bulk_en;
         wr_idx_d  <= wr_idx;
      end
   end

   // R2
   write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take_d |-> vld[wr_idx_d]);

   // R3
   empty_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld == '0) |-> !lk_hit);

   // R4
   bulk_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bulk_en |=> (flush_req && bulk_done));

   // R4
   flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> $past(bulk_en || inv_en));

   // R6
   older_keeps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bulk_en && !newer_mode) |=> (vld[0] == $past(vld[0])));

   // R8
   hint4_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bulk_en && newer_mode && hint == 3'd4) |=> (vld == '0));

   // R9
   hint7_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bulk_en && newer_mode && hint == 3'd7) |=> $stable(vld));

   // R10
   bad_hint_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_hint |-> $past(bulk_en && newer_mode && hint == 3'd5));
endmodule

bind seg_lookaside_buf slb_chk #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .OP_W(OP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .newer_mode (newer_mode),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .inv_en     (inv_en),
   .bulk_en    (bulk_en),
   .bulk_op    (bulk_op),
   .lk_hit     (lk_hit),
   .flush_req  (flush_req),
   .bulk_done  (bulk_done),
   .bad_hint   (bad_hint),
   .vld        (vld_q)
);

// File: tb/test_seg_lookaside_buf.sv
module test_seg_lookaside_buf;
   localparam int N  = 8;
   localparam int EW = 36;
   localparam int VW = 52;
   localparam int OW = 32;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          newer_mode = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [EW-1:0] wr_esid = '0;
   logic [VW-1:0] wr_vsid = '0;
   logic          wr_class = 1'b0;
   logic          inv_en = 1'b0;
   logic [EW-1:0] inv_esid = '0;
   logic          bulk_en = 1'b0;
   logic [OW-1:0] bulk_op = '0;
   logic [EW-1:0] lk_esid = '0;
   logic          lk_hit;
   logic [VW-1:0] lk_vsid;
   logic          flush_req, bulk_done, bad_hint;

   always #10 clk = ~clk;

   seg_lookaside_buf #(.NUM_ENT(N), .ESID_W(EW), .VSID_W(VW), .OP_W(OW)) i_seg_lookaside_buf (
      .clk(clk), .rst_n(rst_n), .newer_mode(newer_mode),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_esid(wr_esid), .wr_vsid(wr_vsid), .wr_class(wr_class),
      .inv_en(inv_en), .inv_esid(inv_esid), .bulk_en(bulk_en), .bulk_op(bulk_op),
      .lk_esid(lk_esid), .lk_hit(lk_hit), .lk_vsid(lk_vsid),
      .flush_req(flush_req), .bulk_done(bulk_done), .bad_hint(bad_hint)
   );

   typedef struct {
      string         req;
      logic          fl, dn, bd, hit;
      logic [VW-1:0] vsid;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fails  = 0;
   bit   finished = 0;

   // Reference model of the table
   bit            m_vld [N];
   bit            m_cls [N];
   logic [EW-1:0] m_esid[N];
   logic [VW-1:0] m_vsid[N];

   function automatic logic [EW-1:0] es(int i);
      return 36'h1_2000_0000 + EW'(i * 17);
   endfunction
   function automatic logic [VW-1:0] vs(int i);
      return 52'hA_BCDE_0000_0000 + VW'(i * 3 + 1);
   endfunction
   function automatic bit cl(int i);
      return (i % 2 == 1) || (i == 0);
   endfunction

   // One cycle of stimulus plus its expected outcome
   task automatic step(input string req, input bit w, input int widx,
                       input logic [EW-1:0] we, input logic [VW-1:0] wv, input bit wc,
                       input bit iv, input logic [EW-1:0] ie,
                       input bit bk, input logic [2:0] hint,
                       input logic [EW-1:0] le);
      exp_t e;
      @(negedge clk);
      wr_en = w; wr_idx = IW'(widx); wr_esid = we; wr_vsid = wv; wr_class = wc;
      inv_en = iv; inv_esid = ie;
      bulk_en = bk; bulk_op = 32'hFC1F_FFFF | ({29'd0, hint} << 21);
      lk_esid = le;
      if (bk) begin
         for (int i = 0; i < N; i++) begin
            bit c;
            c = (i != 0);
            if (newer_mode) begin
               if (hint == 3'd3) c = m_cls[i];
               if (hint == 3'd4) c = 1;
               if (hint == 3'd7) c = 0;
            end
            if (c) m_vld[i] = 0;
         end
      end else if (iv) begin
         for (int i = 0; i < N; i++) if (m_vld[i] && m_esid[i] == ie) m_vld[i] = 0;
      end else if (w) begin
         m_vld[widx] = 1; m_cls[widx] = wc; m_esid[widx] = we; m_vsid[widx] = wv;
      end
      e.req = req;
      e.fl = bk || iv;
      e.dn = bk;
      e.bd = bk && newer_mode && hint == 3'd5;
      e.hit = 0;
      e.vsid = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (m_vld[i] && m_esid[i] == le) begin
            e.hit = 1;
            e.vsid = m_vsid[i];
         end
      end
      q.push_back(e);
   endtask

   task automatic look(input string req, input logic [EW-1:0] le);
      step(req, 0, 0, '0, '0, 0, 0, '0, 0, 3'd0, le);
   endtask
   task automatic wr(input string req, input int i, input logic [EW-1:0] e,
                     input logic [VW-1:0] v, input bit c);
      step(req, 1, i, e, v, c, 0, '0, 0, 3'd0, e);
   endtask
   task automatic bulk(input string req, input logic [2:0] h, input logic [EW-1:0] le);
      step(req, 0, 0, '0, '0, 0, 0, '0, 1, h, le);
   endtask
   task automatic inval(input string req, input logic [EW-1:0] ie, input logic [EW-1:0] le);
      step(req, 0, 0, '0, '0, 0, 1, ie, 0, 3'd0, le);
   endtask
   task automatic fill();
      for (int i = 0; i < N; i++) wr("R2", i, es(i), vs(i), cl(i));
   endtask
   task automatic look_all(input string req);
      for (int i = 0; i < N; i++) look(req, es(i));
   endtask

   // Monitor: compares each cycle's outputs with the queued expectation
   always @(posedge clk) begin
      #5;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_checks++;
         if (flush_req !== e.fl || bulk_done !== e.dn || bad_hint !== e.bd ||
             lk_hit !== e.hit || lk_vsid !== e.vsid) begin
            n_fails++;
            $display("FAIL %s: got fl=%b dn=%b bad=%b hit=%b vsid=%h, expected fl=%b dn=%b bad=%b hit=%b vsid=%h",
                     e.req, flush_req, bulk_done, bad_hint, lk_hit, lk_vsid,
                     e.fl, e.dn, e.bd, e.hit, e.vsid);
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_vld[i] = 0; m_cls[i] = 0; m_esid[i] = '0; m_vsid[i] = '0;
      end
      repeat (3) @(negedge clk);
      lk_esid = es(0);
      #1;
      // R1: reset state seen at the ports
      n_checks++;
      if (lk_hit !== 1'b0 || flush_req !== 1'b0 || bulk_done !== 1'b0 || bad_hint !== 1'b0) begin
         n_fails++;
         $display("FAIL R1: got hit=%b fl=%b dn=%b bad=%b, expected all 0",
                  lk_hit, flush_req, bulk_done, bad_hint);
      end
      @(negedge clk);
      rst_n = 1'b1;
      look("R1", es(3));

      // Older mode
      fill();
      look_all("R3");
      bulk("R6", 3'd3, es(0));
      look_all("R6");
      fill();
      bulk("R10", 3'd5, es(0));
      look_all("R10");
      bulk("R4", 3'd4, es(2));

      // Newer mode, switched while idle
      look("R1", es(0));
      newer_mode = 1'b1;
      fill();
      bulk("R6", 3'd0, es(0));
      look_all("R6");
      fill();
      bulk("R5", 3'd6, es(1));
      look_all("R5");
      fill();
      bulk("R7", 3'd3, es(0));
      look_all("R7");
      fill();
      bulk("R8", 3'd4, es(0));
      look_all("R8");
      bulk("R4", 3'd4, es(0));
      fill();
      bulk("R9", 3'd7, es(5));
      look_all("R9");
      bulk("R10", 3'd5, es(0));
      look_all("R10");
      fill();
      inval("R11", es(4), es(4));
      look_all("R11");
      inval("R11", 36'h0_DEAD_0000, es(3));
      // R12: invalidate beats write; bulk beats single invalidate
      step("R12", 1, 4, 36'h0_0000_0F00, 52'h1_2345, 0, 1, es(1), 0, 3'd0, 36'h0_0000_0F00);
      look("R12", 36'h0_0000_0F00);
      look("R12", es(1));
      step("R12", 1, 3, 36'h0_0000_0F11, 52'h5_4321, 0, 1, es(2), 1, 3'd7, es(2));
      look("R12", 36'h0_0000_0F11);
      look("R12", es(3));
      // R3: duplicate identifier, lowest index wins
      wr("R3", 6, es(2), 52'h7_7777, 0);
      look("R3", es(2));
      inval("R3", es(2), es(2));
      look("R3", es(6));
      repeat (2) look("R1", es(0));
      @(negedge clk);
      @(negedge clk);
      summary();
   end
endmodule